// File: doc/BRIEF.md
# EDO Page-Mode DRAM Controller

This block sits between a simple request port and a 16-bit extended-data-out DRAM whose row and column addresses share one set of address pins. A request carries a 22-bit word address, a read/write flag, a 2-bit byte-lane mask and write data. The controller opens the addressed row, runs a column cycle, and leaves the row open while the following request goes to the same row. In that case it runs further column cycles without a new row activation. A request to another row, a refresh request from outside, or the approach of the longest allowed row-open time closes the row first.

The two byte lanes have separate column strobes, so byte writes need no read-modify-write. Every write is an early write: the write strobe is low before any column strobe falls and the output enable stays off. Because of this the memory never drives the data pins during a write. Read data remains valid after the column strobe rises, so the controller captures it at the end of the column precharge phase. It returns the data with a one-cycle valid pulse. All timing is given in clock counts through parameters.

Top module: `edo_page_ctrl`

## Requirements
- R1: The row `reqAddr[21:10]` is on `dramAddr` in the cycle before and the cycle in which `dramRasN` falls. The column `reqAddr[9:0]` (upper two pins zero) is on `dramAddr` in the cycle before and the cycle in which a column strobe falls.
- R2: `reqBe[0]` enables the lower lane (data bits 7:0, `dramCasLN`), and `reqBe[1]` enables the upper lane (bits 15:8, `dramCasHN`). Both bits set strobe both lanes. A lane whose bit is clear is never strobed, so its stored byte is kept.
- R3: For a write, `dramWeN` is low for at least one cycle before a column strobe falls, and `dramOeN` is high whenever `dramWeN` is low.
- R4: When both lanes are strobed in a column cycle, their strobes fall in the same cycle and rise in the same cycle.
- R5: A read returns its data on `rspData` with `rspValid` high for exactly one cycle, in request order. Bytes of disabled lanes read as 0x00.
- R6: Requests that hit the open row at the end of a column cycle are served in further column cycles while `dramRasN` stays low. There is one row activation for the group.
- R7: A request to another row closes the page. `dramRasN` stays high for at least `RP_CYC` cycles before it falls again.
- R8: While `refReq` is high, `reqReady` is low. An open page is closed at the end of the current column cycle, and `dramRasN` stays high.
- R9: `dramRasN` is never low for more than `RAS_MAX_CYC` consecutive cycles. The page is closed early when another column cycle would exceed that count.
- R10: `reqReady` is high only in the idle state, or in the last cycle of a column cycle when the waiting request hits the open row. It is low while a column strobe is low.
- R11: After reset all strobes (`dramRasN`, `dramCasLN`, `dramCasHN`, `dramWeN`, `dramOeN`) are high, `dramDqOe` and `rspValid` are low, and `reqReady` is high when `refReq` is low.
- R12: During a write column cycle, `dramDqOe` is high and `dramDqOut` carries the request's write data. `dramDqOe` is high only when `dramWeN` is low and `dramOeN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Request taken at this edge when valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 22 | Word address, row in upper 12 bits |
| reqBe | input | 2 | Byte-lane enables |
| reqWdata | input | 16 | Write data |
| refReq | input | 1 | External refresh wants the memory idle |
| rspValid | output | 1 | One-cycle read data valid |
| rspData | output | 16 | Read data, disabled lanes zero |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasLN | output | 1 | Lower-lane column strobe, active low |
| dramCasHN | output | 1 | Upper-lane column strobe, active low |
| dramWeN | output | 1 | Write strobe, active low |
| dramOeN | output | 1 | Output enable, active low |
| dramAddr | output | 12 | Multiplexed row/column address |
| dramDqOut | output | 16 | Data toward the memory |
| dramDqOe | output | 1 | Enable for the data pad drivers |
| dramDqIn | input | 16 | Data from the memory |

## Verification
The bench places a behavioural memory on the pins and chains requests to one row back to back. A controller that reopened the row on every hit would show extra row activations. One that kept the row open too long would break the row-low limit, so a group of four hits must split into two pages. Lane-masked writes followed by reads catch swapped strobes and lanes that were written but should have kept their bytes. Masked reads catch unmasked response bytes. The memory model also tests each write strobe against the column strobe edges. A late write, mixed lane edges, or a drive while the output enable is active would each be reported. A refresh request raised in the middle of a page must close it and hold back the waiting request. A controller that ignored it would keep the row open or accept the request.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RSET,
    ST_ACT,
    ST_CSET,
    ST_CAS,
    ST_CP,
    ST_PRE
  } edoState_t;

  typedef struct packed {
    logic loadReq;
    logic rasOn;
    logic selCol;
    logic casOn;
    logic weOn;
    logic oeOn;
    logic dqDrive;
    logic capture;
  } edoStrobe_t;

endpackage

// File: rtl/edo_ctrl.sv
module edo_ctrl import edo_pkg::*; #(
  parameter int RCD_CYC     = 5,
  parameter int CAS_CYC     = 2,
  parameter int CP_CYC      = 2,
  parameter int RP_CYC      = 6,
  parameter int RAS_MAX_CYC = 2000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       rowHit,
  input  logic       curWrite,
  input  logic       refReq,
  output logic       reqReady,
  output edoStrobe_t strobe
);

  localparam int PAGE_CYC = 1 + CAS_CYC + CP_CYC;
  localparam int CNT_W    = $clog2(RCD_CYC + CAS_CYC + CP_CYC + RP_CYC + 1);
  localparam int RAS_W    = $clog2(RAS_MAX_CYC + PAGE_CYC + 1);
  localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(RCD_CYC - 1);
  localparam logic [CNT_W-1:0] CAS_LD = CNT_W'(CAS_CYC - 1);
  localparam logic [CNT_W-1:0] CP_LD  = CNT_W'(CP_CYC - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(RP_CYC - 1);
  localparam logic [RAS_W-1:0] PAGE_W = RAS_W'(PAGE_CYC);
  localparam logic [RAS_W-1:0] LIM_W  = RAS_W'(RAS_MAX_CYC);

  edoState_t        state, stateNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic [RAS_W-1:0] rasCnt;
  logic             lastCp, rasMaxHit, accept, inCol;

  assign lastCp    = (state == ST_CP) && (cnt == '0);
  assign rasMaxHit = (rasCnt + PAGE_W) >= LIM_W;
  assign reqReady  = !refReq &&
                     ((state == ST_IDLE) || (lastCp && rowHit && !rasMaxHit));
  assign accept    = reqReady && reqValid;
  assign inCol     = (state == ST_CSET) || (state == ST_CAS) || (state == ST_CP);

  always_comb begin
    stateNxt = state;
    cntNxt   = (cnt == '0) ? '0 : cnt - 1'b1;
    unique case (state)
      ST_IDLE: if (accept) stateNxt = ST_RSET;
      ST_RSET: begin stateNxt = ST_ACT; cntNxt = RCD_LD; end
      ST_ACT:  if (cnt == '0) stateNxt = ST_CSET;
      ST_CSET: begin stateNxt = ST_CAS; cntNxt = CAS_LD; end
      ST_CAS:  if (cnt == '0) begin stateNxt = ST_CP; cntNxt = CP_LD; end
      ST_CP:   if (cnt == '0) begin
                 if (accept) stateNxt = ST_CSET;
                 else begin stateNxt = ST_PRE; cntNxt = RP_LD; end
               end
      ST_PRE:  if (cnt == '0) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      rasCnt <= '0;
    end else begin
      state  <= stateNxt;
      cnt    <= cntNxt;
      rasCnt <= strobe.rasOn ? rasCnt + 1'b1 : '0;
    end
  end

  always_comb begin
    strobe.loadReq = accept;
    strobe.rasOn   = (state == ST_ACT) || inCol;
    strobe.selCol  = inCol;
    strobe.casOn   = (state == ST_CAS);
    strobe.weOn    = curWrite && inCol;
    strobe.oeOn    = !curWrite && ((state == ST_CAS) || (state == ST_CP));
    strobe.dqDrive = curWrite && inCol;
    strobe.capture = lastCp && !curWrite;
  end

endmodule

// File: rtl/edo_datapath.sv
module edo_datapath import edo_pkg::*; #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 10,
  parameter int DATA_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  edoStrobe_t                           strobe,
  input  logic                                 reqWrite,
  input  logic [ROW_W+COL_W-1:0]               reqAddr,
  input  logic [1:0]                           reqBe,
  input  logic [DATA_W-1:0]                    reqWdata,
  output logic                                 rowHit,
  output logic                                 curWrite,
  output logic                                 dramRasN,
  output logic                                 dramCasLN,
  output logic                                 dramCasHN,
  output logic                                 dramWeN,
  output logic                                 dramOeN,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0] dramAddr,
  output logic [DATA_W-1:0]                    dramDqOut,
  output logic                                 dramDqOe,
  input  logic [DATA_W-1:0]                    dramDqIn,
  output logic                                 rspValid,
  output logic [DATA_W-1:0]                    rspData
);

  localparam int ADDR_W = ROW_W + COL_W;
  localparam int PIN_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int LANES  = 2;
  localparam int LANE_W = DATA_W / LANES;

  logic [ROW_W-1:0]  curRow;
  logic [COL_W-1:0]  curCol;
  logic [LANES-1:0]  curBe;
  logic [DATA_W-1:0] curWdata, maskedIn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curRow   <= '0;
      curCol   <= '0;
      curBe    <= '0;
      curWrite <= 1'b0;
      curWdata <= '0;
    end else if (strobe.loadReq) begin
      curRow   <= reqAddr[ADDR_W-1:COL_W];
      curCol   <= reqAddr[COL_W-1:0];
      curBe    <= reqBe;
      curWrite <= reqWrite;
      curWdata <= reqWdata;
    end
  end

  assign rowHit    = (reqAddr[ADDR_W-1:COL_W] == curRow);
  assign dramRasN  = !strobe.rasOn;
  assign dramCasLN = !(strobe.casOn && curBe[0]);
  assign dramCasHN = !(strobe.casOn && curBe[1]);
  assign dramWeN   = !strobe.weOn;
  assign dramOeN   = !strobe.oeOn;
  assign dramAddr  = strobe.selCol ? PIN_W'(curCol) : PIN_W'(curRow);
  assign dramDqOut = curWdata;
  assign dramDqOe  = strobe.dqDrive;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign maskedIn[g*LANE_W +: LANE_W] =
      curBe[g] ? dramDqIn[g*LANE_W +: LANE_W] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strobe.capture;
      if (strobe.capture) rspData <= maskedIn;
    end
  end

endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl import edo_pkg::*; #(
  parameter int ROW_W       = 12,
  parameter int COL_W       = 10,
  parameter int DATA_W      = 16,
  parameter int RCD_CYC     = 5,
  parameter int CAS_CYC     = 2,
  parameter int CP_CYC      = 2,
  parameter int RP_CYC      = 6,
  parameter int RAS_MAX_CYC = 2000
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 reqValid,
  output logic                                 reqReady,
  input  logic                                 reqWrite,
  input  logic [ROW_W+COL_W-1:0]               reqAddr,
  input  logic [1:0]                           reqBe,
  input  logic [DATA_W-1:0]                    reqWdata,
  input  logic                                 refReq,
  output logic                                 rspValid,
  output logic [DATA_W-1:0]                    rspData,
  output logic                                 dramRasN,
  output logic                                 dramCasLN,
  output logic                                 dramCasHN,
  output logic                                 dramWeN,
  output logic                                 dramOeN,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0] dramAddr,
  output logic [DATA_W-1:0]                    dramDqOut,
  output logic                                 dramDqOe,
  input  logic [DATA_W-1:0]                    dramDqIn
);

  edoStrobe_t strobe;
  logic       rowHit, curWrite;

  edo_ctrl #(
    .RCD_CYC(RCD_CYC), .CAS_CYC(CAS_CYC), .CP_CYC(CP_CYC),
    .RP_CYC(RP_CYC), .RAS_MAX_CYC(RAS_MAX_CYC)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .rowHit(rowHit),
    .curWrite(curWrite), .refReq(refReq), .reqReady(reqReady), .strobe(strobe)
  );

  edo_datapath #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata),
    .rowHit(rowHit), .curWrite(curWrite),
    .dramRasN(dramRasN), .dramCasLN(dramCasLN), .dramCasHN(dramCasHN),
    .dramWeN(dramWeN), .dramOeN(dramOeN), .dramAddr(dramAddr),
    .dramDqOut(dramDqOut), .dramDqOe(dramDqOe), .dramDqIn(dramDqIn),
    .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: rtl/edo_page_chk.sv
module edo_page_chk #(
  parameter int PIN_W       = 12,
  parameter int RP_CYC      = 6,
  parameter int RAS_MAX_CYC = 2000
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqReady,
  input logic             refReq,
  input logic             rspValid,
  input logic             dramRasN,
  input logic             dramCasLN,
  input logic             dramCasHN,
  input logic             dramWeN,
  input logic             dramOeN,
  input logic [PIN_W-1:0] dramAddr,
  input logic             dramDqOe
);

  localparam int HW = $clog2(RP_CYC + 2) + 1;
  localparam int LW = $clog2(RAS_MAX_CYC + 2) + 1;

  logic [HW-1:0] highCnt;
  logic [LW-1:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highCnt <= HW'(RP_CYC);
      lowCnt  <= '0;
    end else begin
      if (!dramRasN) highCnt <= '0;
      else if (highCnt < HW'(RP_CYC)) highCnt <= highCnt + 1'b1;
      lowCnt <= dramRasN ? '0 : lowCnt + 1'b1;
    end
  end

  p_row_setup_r1: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> $stable(dramAddr));
  p_col_setup_r1: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(dramCasLN) || $fell(dramCasHN)) |-> $stable(dramAddr));
  p_early_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (($fell(dramCasLN) || $fell(dramCasHN)) && !dramWeN) |-> ($past(dramWeN) == 1'b0));
  p_oe_off_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    !dramWeN |-> dramOeN);
  p_lane_mode_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!dramCasLN && !dramCasHN) |-> ($past(dramCasLN) == $past(dramCasHN)));
  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);
  p_cas_in_row_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!dramCasLN || !dramCasHN) |-> !dramRasN);
  p_precharge_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> (highCnt >= HW'(RP_CYC)));
  p_ref_block_r8: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> !reqReady);
  p_ras_max_r9: assert property (@(posedge clk) disable iff (!rstN)
    lowCnt <= LW'(RAS_MAX_CYC));
  p_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!dramCasLN || !dramCasHN) |-> !reqReady);
  p_drive_r12: assert property (@(posedge clk) disable iff (!rstN)
    dramDqOe |-> (!dramWeN && dramOeN));

endmodule

bind edo_page_ctrl edo_page_chk #(
  .PIN_W((ROW_W > COL_W) ? ROW_W : COL_W),
  .RP_CYC(RP_CYC),
  .RAS_MAX_CYC(RAS_MAX_CYC)
) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .refReq(refReq),
  .rspValid(rspValid), .dramRasN(dramRasN), .dramCasLN(dramCasLN),
  .dramCasHN(dramCasHN), .dramWeN(dramWeN), .dramOeN(dramOeN),
  .dramAddr(dramAddr), .dramDqOe(dramDqOe)
);

// File: tb/edo_page_ctrl_tb.sv
`timescale 1ns/1ps
module edo_page_ctrl_tb;

  localparam int RP  = 6;
  localparam int RMX = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, refReq = 1'b0;
  logic [21:0] reqAddr = '0;
  logic [1:0]  reqBe = '0;
  logic [15:0] reqWdata = '0;
  logic        reqReady, rspValid;
  logic [15:0] rspData;
  logic        dramRasN, dramCasLN, dramCasHN, dramWeN, dramOeN, dramDqOe;
  logic [11:0] dramAddr;
  logic [15:0] dramDqOut, dramDqIn;

  always #2.5 clk = ~clk;

  edo_page_ctrl #(.RP_CYC(RP), .RAS_MAX_CYC(RMX)) u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqBe(reqBe), .reqWdata(reqWdata),
    .refReq(refReq), .rspValid(rspValid), .rspData(rspData),
    .dramRasN(dramRasN), .dramCasLN(dramCasLN), .dramCasHN(dramCasHN),
    .dramWeN(dramWeN), .dramOeN(dramOeN), .dramAddr(dramAddr),
    .dramDqOut(dramDqOut), .dramDqOe(dramDqOe), .dramDqIn(dramDqIn)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] dflt(input logic [21:0] k);
    return k[15:0] ^ 16'h5A3C;
  endfunction

  // behavioural memory on the pins
  logic [15:0] mem    [logic [21:0]];
  logic [15:0] shadow [logic [21:0]];
  logic [11:0] mRow = '0;
  logic [9:0]  mCol = '0;
  logic [15:0] mRd = 16'hFFFF;
  logic        pRas = 1'b1, pCasL = 1'b1, pCasH = 1'b1, pWe = 1'b1;
  int          hiCnt = 100, rasFalls = 0;

  assign dramDqIn = (!dramRasN && !dramOeN && dramWeN) ? mRd : 16'hFFFF;

  always @(negedge clk) begin
    if (rstN) begin
      if (pRas && !dramRasN) begin
        mRow = dramAddr;
        rasFalls++;
        chk(hiCnt >= RP, "R7 precharge", hiCnt, RP);
      end
      if ((pCasL && !dramCasLN) || (pCasH && !dramCasHN)) begin
        logic [21:0] k;
        logic [15:0] cur;
        mCol = dramAddr[9:0];
        k = {mRow, mCol};
        chk((pCasL || dramCasLN) && (pCasH || dramCasHN), "R4 lanes",
            {pCasL, pCasH}, 2'b11);
        chk(!reqReady, "R10 busy", reqReady, 0);
        cur = mem.exists(k) ? mem[k] : dflt(k);
        if (!dramWeN) begin
          chk(!pWe, "R3 early", pWe, 0);
          chk(dramDqOe && dramOeN, "R12 drive", {dramDqOe, dramOeN}, 2'b11);
          if (!dramCasLN) cur[7:0]  = dramDqOut[7:0];
          if (!dramCasHN) cur[15:8] = dramDqOut[15:8];
          mem[k] = cur;
        end
        mRd = {dramCasHN ? 8'hFF : cur[15:8], dramCasLN ? 8'hFF : cur[7:0]};
      end
      hiCnt = dramRasN ? hiCnt + 1 : 0;
    end
    pRas = dramRasN; pCasL = dramCasLN; pCasH = dramCasHN; pWe = dramWeN;
  end

  // scoreboard monitor
  logic [15:0] expQ[$];
  always @(negedge clk) begin
    if (rstN && rspValid) begin
      if (expQ.size() == 0) chk(1'b0, "R5 extra rsp", rspData, 0);
      else begin
        logic [15:0] e;
        e = expQ.pop_front();
        chk(rspData == e, "R5 read data", rspData, e);
      end
    end
  end

  task automatic doReq(input bit wr, input logic [21:0] a, input logic [1:0] be,
                       input logic [15:0] d);
    logic [15:0] s;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqBe = be; reqWdata = d;
    #1;
    while (!reqReady) begin @(negedge clk); #1; end
    s = shadow.exists(a) ? shadow[a] : dflt(a);
    if (wr) begin
      if (be[0]) s[7:0]  = d[7:0];
      if (be[1]) s[15:8] = d[15:8];
      shadow[a] = s;
    end else begin
      expQ.push_back({be[1] ? s[15:8] : 8'h00, be[0] ? s[7:0] : 8'h00});
    end
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic drain();
    repeat (25) @(negedge clk);
  endtask

  localparam logic [21:0] A = {12'd5, 10'd3};
  localparam logic [21:0] B = {12'd5, 10'd4};

  int base;

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk({dramRasN, dramCasLN, dramCasHN, dramWeN, dramOeN} == 5'h1F, "R11 strobes",
        {dramRasN, dramCasLN, dramCasHN, dramWeN, dramOeN}, 5'h1F);
    chk(!dramDqOe && !rspValid, "R11 idle outputs", {dramDqOe, rspValid}, 0);
    chk(reqReady, "R11 ready", reqReady, 1);

    // R6 page hits, R1/R2 lanes
    base = rasFalls;
    doReq(1, A, 2'b11, 16'h1234);
    doReq(1, B, 2'b01, 16'hAB77);
    doReq(0, A, 2'b11, 16'h0);
    drain();
    chk(rasFalls - base == 1, "R6 one activation", rasFalls - base, 1);
    chk(mem.exists(A) && mem[A] == 16'h1234, "R1 address split",
        mem.exists(A) ? mem[A] : 16'hDEAD, 16'h1234);
    chk(mem.exists(B) && mem[B] == {dflt(B) >> 8, 8'h77}, "R2 lower lane only",
        mem.exists(B) ? mem[B] : 16'hDEAD, {dflt(B) >> 8, 8'h77});

    // R5 masking, R7 row miss
    base = rasFalls;
    doReq(0, B, 2'b10, 16'h0);
    doReq(0, B, 2'b01, 16'h0);
    doReq(0, {12'd9, 10'd0}, 2'b11, 16'h0);
    drain();
    chk(rasFalls - base == 2, "R7 row miss reopens", rasFalls - base, 2);

    // R9 row-low limit splits a long run
    base = rasFalls;
    for (int i = 0; i < 4; i++) doReq(0, {12'd7, 10'(i)}, 2'b11, 16'h0);
    drain();
    chk(rasFalls - base == 2, "R9 page split", rasFalls - base, 2);

    // R8 refresh request closes page and blocks
    base = rasFalls;
    doReq(1, {12'd3, 10'd1}, 2'b10, 16'hC3FF);
    refReq = 1'b1;
    fork
      doReq(0, {12'd3, 10'd1}, 2'b11, 16'h0);
      begin
        repeat (30) @(negedge clk);
        chk(dramRasN, "R8 row closed", dramRasN, 1);
        chk(!reqReady, "R8 ready held", reqReady, 0);
        refReq = 1'b0;
      end
    join
    drain();
    chk(rasFalls - base == 2, "R8 reopen after refresh", rasFalls - base, 2);
    chk(expQ.size() == 0, "R5 all responses", expQ.size(), 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule